// File: doc/BRIEF.md
# Cascaded Interrupt Status Aggregator

This block collects event pulses from the receive and transmit paths of a network interface into sticky status bits and reduces them to one level-sensitive interrupt line. A second, 16-bit status/mask pair serves the PHY management unit. Any unmasked bit in that pair is folded into a single summary position (bit 23) of the main interrupt computation.

Software reaches four registers through a 32-bit word-wide read/write port. Reading a status register returns its present contents and clears it in the same access. The main status read keeps bit 23; the management status read clears everything. The main status and main mask each answer at a second alias offset. This lets older drivers that use the shifted offsets work unchanged.

Register map (12-bit byte offsets): main status 0x100 (alias 0x108), main mask 0x104 (alias 0x10C), management status 0x200, management mask 0x204.

Top module: `irq_cascade_agg`

## Requirements
- R1: After reset the main mask reads 0xFF7FFFFF and the management mask reads 0x0000FFFF. Both status registers read 0, and `irq` is low.
- R2: A one-cycle pulse on `evt_rx_host`, `evt_tx_desc` or `evt_tx_drain` sets main status bit 16, 24 or 25 respectively. A pulse on `mgmt_evt[i]` sets management status bit i. Each bit stays set until it is cleared.
- R3: A read of main status returns its current value. From the next cycle every bit except bit 23 is zero.
- R4: A read of management status returns its current value. From the next cycle the whole register is zero.
- R5: Offsets 0x108 and 0x10C behave exactly like 0x100 and 0x104, for reads, writes and read-clear.
- R6: A mask bit of 1 blocks its status bit and a mask bit of 0 passes it. `irq` is high exactly when some passed main bit other than 23, or some passed management bit, is set.
- R7: Main status bit 23 never raises `irq` through the main mask, even when main mask bit 23 is 0.
- R8: Any set management status bit whose management mask bit is 0 raises `irq`, whatever the main mask holds.
- R9: When an event pulse and a read-clear of the same status bit fall in one cycle, the bit is set afterwards.
- R10: `irq` is registered. It reflects the status and mask contents of the previous cycle.
- R11: Reads of unmapped offsets return 0, and writes to them change nothing. `reg_rdata` is 0 when no read is in progress.
- R12: A write stores the word into the addressed register. Management registers keep only bits 15:0 and read upper bits as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read-clear applies at this edge) |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle `reg_rd` is high |
| evt_rx_host | input | 1 | Receive frame delivered pulse |
| evt_tx_desc | input | 1 | Transmit descriptor consumed pulse |
| evt_tx_drain | input | 1 | Transmit queue drained pulse |
| mgmt_evt | input | 16 | Management-unit event pulses, one per status bit |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach is the collision between an event pulse and a read-clear of the same register in one cycle. The bench raises the pulse while it holds the read strobe. It checks that the returned word lacks the new bit and that a following read shows it. The same is done for a management bit. The bench also leaves bit 23 set in the main status and then opens the whole main mask. This shows that the summary position cannot raise the line by itself. A masked main path is then paired with an unmasked management bit to show the cascade acts alone.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int DATA_W    = 32;
    localparam int MGMT_W    = 16;
    localparam int ADDR_W    = 12;
    localparam int CASCADE_B = 23;
    localparam int EVT_N     = 3;
    // event index 0: rx to host, 1: tx descriptor done, 2: tx drained
    localparam int EVT_POS [EVT_N] = '{16, 24, 25};

    localparam logic [ADDR_W-1:0] OFS_MAIN_ST   = 12'h100;
    localparam logic [ADDR_W-1:0] OFS_MAIN_MK   = 12'h104;
    localparam logic [ADDR_W-1:0] OFS_MAIN_ST_A = 12'h108;
    localparam logic [ADDR_W-1:0] OFS_MAIN_MK_A = 12'h10C;
    localparam logic [ADDR_W-1:0] OFS_MGMT_ST   = 12'h200;
    localparam logic [ADDR_W-1:0] OFS_MGMT_MK   = 12'h204;

    localparam logic [DATA_W-1:0] MAIN_MK_RST = 32'hFF7F_FFFF;
    localparam logic [MGMT_W-1:0] MGMT_MK_RST = 16'hFFFF;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_MAIN_ST,
        TGT_MAIN_MK,
        TGT_MGMT_ST,
        TGT_MGMT_MK
    } reg_tgt_e;
endpackage

// File: rtl/irq_agg_decode.sv
module irq_agg_decode
    import irq_agg_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output reg_tgt_e          tgt
);
    always_comb begin
        unique case (addr)
            OFS_MAIN_ST, OFS_MAIN_ST_A: tgt = TGT_MAIN_ST;
            OFS_MAIN_MK, OFS_MAIN_MK_A: tgt = TGT_MAIN_MK;
            OFS_MGMT_ST:                tgt = TGT_MGMT_ST;
            OFS_MGMT_MK:                tgt = TGT_MGMT_MK;
            default:                    tgt = TGT_NONE;
        endcase
    end
endmodule

// File: rtl/irq_agg_main_reg.sv
module irq_agg_main_reg
    import irq_agg_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NE = EVT_N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_st,
    input  logic          wr_mk,
    input  logic          rd_st,
    input  logic [DW-1:0] wdata,
    input  logic [NE-1:0] evt,
    output logic [DW-1:0] st_q,
    output logic [DW-1:0] mk_q
);
    localparam logic [DW-1:0] KEEP = DW'(1) << CASCADE_B;

    logic [DW-1:0] set_vec;
    logic [DW-1:0] st_d;

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NE; i++) begin
            set_vec[EVT_POS[i]] = set_vec[EVT_POS[i]] | evt[i];
        end
    end

    always_comb begin
        if (wr_st)      st_d = wdata;
        else if (rd_st) st_d = st_q & KEEP;
        else            st_d = st_q;
        st_d = st_d | set_vec;   // events win over clear and write
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            mk_q <= MAIN_MK_RST;
        end else begin
            st_q <= st_d;
            if (wr_mk) mk_q <= wdata;
        end
    end

    for (genvar g = 0; g < NE; g++) begin : g_evt_chk
        p_evt_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
            evt[g] |=> st_q[EVT_POS[g]]);
    end

    p_rdclr_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_st && !wr_st && evt == '0) |=> (st_q == ($past(st_q) & KEEP)));
endmodule

// File: rtl/irq_agg_mgmt_reg.sv
module irq_agg_mgmt_reg
    import irq_agg_pkg::*;
#(
    parameter int MW = MGMT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_st,
    input  logic          wr_mk,
    input  logic          rd_st,
    input  logic [MW-1:0] wdata,
    input  logic [MW-1:0] evt,
    output logic [MW-1:0] st_q,
    output logic [MW-1:0] mk_q
);
    logic [MW-1:0] st_d;

    always_comb begin
        if (wr_st)      st_d = wdata;
        else if (rd_st) st_d = '0;
        else            st_d = st_q;
        st_d = st_d | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            mk_q <= MGMT_MK_RST;
        end else begin
            st_q <= st_d;
            if (wr_mk) mk_q <= wdata;
        end
    end

    p_rdclr_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_st && !wr_st && evt == '0) |=> (st_q == '0));
    p_evt_sticky_mgmt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt != '0) |=> ((st_q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/irq_cascade_agg.sv
module irq_cascade_agg
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              evt_rx_host,
    input  logic              evt_tx_desc,
    input  logic              evt_tx_drain,
    input  logic [MGMT_W-1:0] mgmt_evt,
    output logic              irq
);
    localparam logic [DATA_W-1:0] SUMMARY = DATA_W'(1) << CASCADE_B;

    reg_tgt_e          tgt;
    logic [DATA_W-1:0] main_st, main_mk;
    logic [MGMT_W-1:0] mgmt_st, mgmt_mk;
    logic              main_hit, mgmt_hit;

    irq_agg_decode i_dec (
        .addr (reg_addr),
        .tgt  (tgt)
    );

    irq_agg_main_reg #(.DW(DATA_W), .NE(EVT_N)) i_main (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_st (reg_wr && tgt == TGT_MAIN_ST),
        .wr_mk (reg_wr && tgt == TGT_MAIN_MK),
        .rd_st (reg_rd && tgt == TGT_MAIN_ST),
        .wdata (reg_wdata),
        .evt   ({evt_tx_drain, evt_tx_desc, evt_rx_host}),
        .st_q  (main_st),
        .mk_q  (main_mk)
    );

    irq_agg_mgmt_reg #(.MW(MGMT_W)) i_mgmt (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_st (reg_wr && tgt == TGT_MGMT_ST),
        .wr_mk (reg_wr && tgt == TGT_MGMT_MK),
        .rd_st (reg_rd && tgt == TGT_MGMT_ST),
        .wdata (reg_wdata[MGMT_W-1:0]),
        .evt   (mgmt_evt),
        .st_q  (mgmt_st),
        .mk_q  (mgmt_mk)
    );

    // summary position is reachable only through the cascade
    assign mgmt_hit = |(mgmt_st & ~mgmt_mk);
    assign main_hit = |(main_st & ~main_mk & ~SUMMARY);

    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= main_hit | mgmt_hit;
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_rd) begin
            unique case (tgt)
                TGT_MAIN_ST: reg_rdata = main_st;
                TGT_MAIN_MK: reg_rdata = main_mk;
                TGT_MGMT_ST: reg_rdata = DATA_W'(mgmt_st);
                TGT_MGMT_MK: reg_rdata = DATA_W'(mgmt_mk);
                default:     reg_rdata = '0;
            endcase
        end
    end

    p_cascade_raise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_hit |=> irq);
    p_summary_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mgmt_hit && (main_st & ~main_mk) == (main_st & ~main_mk & SUMMARY)) |=> !irq);
    p_rdata_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |-> reg_rdata == '0);
endmodule

// File: tb/test_irq_cascade_agg.sv
module test_irq_cascade_agg;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        evt_rx_host = 1'b0, evt_tx_desc = 1'b0, evt_tx_drain = 1'b0;
    logic [15:0] mgmt_evt = '0;
    logic        irq;
    int          n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    irq_cascade_agg i_irq_cascade_agg (.*);

    // {req, is_write, addr, wdata, expected read}
    localparam int NV = 17;
    localparam logic [80:0] VEC [NV] = '{
        {4'd1,  1'b0, 12'h104, 32'h0,         32'hFF7F_FFFF}, // R1
        {4'd5,  1'b0, 12'h10C, 32'h0,         32'hFF7F_FFFF}, // R5
        {4'd1,  1'b0, 12'h204, 32'h0,         32'h0000_FFFF}, // R1
        {4'd1,  1'b0, 12'h200, 32'h0,         32'h0},         // R1
        {4'd12, 1'b1, 12'h104, 32'h1234_5678, 32'h0},
        {4'd5,  1'b0, 12'h10C, 32'h0,         32'h1234_5678}, // R5
        {4'd5,  1'b1, 12'h108, 32'h0081_0001, 32'h0},
        {4'd3,  1'b0, 12'h100, 32'h0,         32'h0081_0001}, // R3
        {4'd3,  1'b0, 12'h108, 32'h0,         32'h0080_0000}, // R3
        {4'd12, 1'b1, 12'h200, 32'h0000_ABCD, 32'h0},
        {4'd4,  1'b0, 12'h200, 32'h0,         32'h0000_ABCD}, // R4
        {4'd4,  1'b0, 12'h200, 32'h0,         32'h0},         // R4
        {4'd11, 1'b1, 12'h300, 32'hDEAD_BEEF, 32'h0},
        {4'd11, 1'b0, 12'h300, 32'h0,         32'h0},         // R11
        {4'd12, 1'b1, 12'h204, 32'hFFFF_1234, 32'h0},
        {4'd12, 1'b0, 12'h204, 32'h0,         32'h0000_1234}, // R12
        {4'd11, 1'b0, 12'h100, 32'h0,         32'h0080_0000}  // R11
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog: actual %08h expected %08h", 32'h0, 32'h1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        @(negedge clk); tick(); tick();
        rst_n = 1'b1;
        tick();
        chk(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'h0);
        chk(reg_rdata == '0, "R11 idle rdata", reg_rdata, 32'h0);

        for (int k = 0; k < NV; k++) begin
            if (VEC[k][76]) begin
                bus_wr(VEC[k][75:64], VEC[k][63:32]);
            end else begin
                bus_rd(VEC[k][75:64], rd);
                n_chk++;
                if (rd !== VEC[k][31:0]) begin
                    n_bad++;
                    $display("FAIL R%0d vector %0d: actual %08h expected %08h",
                             VEC[k][80:77], k, rd, VEC[k][31:0]);
                end
            end
        end

        // R7: summary bit set, main mask fully open, management masked
        bus_wr(12'h104, 32'h0);
        bus_wr(12'h204, 32'h0000_FFFF);
        tick(); tick();
        chk(irq == 1'b0, "R7 summary bit alone", 32'(irq), 32'h0);

        // R10 / R6 / R2: rx event through an open bit 16
        bus_wr(12'h104, 32'hFFFE_FFFF);
        tick(); tick();
        evt_rx_host = 1'b1;
        tick();
        evt_rx_host = 1'b0;
        chk(irq == 1'b0, "R10 irq one cycle late", 32'(irq), 32'h0);
        tick();
        chk(irq == 1'b1, "R6 unmasked event raises irq", 32'(irq), 32'h1);
        bus_rd(12'h100, rd);
        chk(rd == 32'h0081_0000, "R2 rx bit 16 sticky", rd, 32'h0081_0000);
        tick();
        chk(irq == 1'b0, "R3 read-clear drops irq", 32'(irq), 32'h0);

        // R6 masked event, R2 drain bit 25
        bus_wr(12'h104, 32'hFFFF_FFFF);
        evt_tx_drain = 1'b1;
        tick();
        evt_tx_drain = 1'b0;
        tick(); tick();
        chk(irq == 1'b0, "R6 masked event silent", 32'(irq), 32'h0);
        bus_rd(12'h100, rd);
        chk(rd == 32'h0280_0000, "R2 drain bit 25", rd, 32'h0280_0000);

        // R8: cascade with main path fully masked
        bus_wr(12'h204, 32'h0000_FFFE);
        mgmt_evt = 16'h0001;
        tick();
        mgmt_evt = '0;
        tick();
        chk(irq == 1'b1, "R8 cascade raises irq", 32'(irq), 32'h1);
        bus_rd(12'h200, rd);
        chk(rd == 32'h1, "R4 mgmt status value", rd, 32'h1);
        tick();
        chk(irq == 1'b0, "R4 mgmt clear drops irq", 32'(irq), 32'h0);

        // R9: event collides with read-clear
        reg_rd = 1'b1; reg_addr = 12'h100; evt_tx_desc = 1'b1;
        #1 rd = reg_rdata;
        tick();
        reg_rd = 1'b0; evt_tx_desc = 1'b0;
        chk(rd == 32'h0080_0000, "R9 read value before event", rd, 32'h0080_0000);
        bus_rd(12'h100, rd);
        chk(rd == 32'h0180_0000, "R9 main event survives clear", rd, 32'h0180_0000);
        reg_rd = 1'b1; reg_addr = 12'h200; mgmt_evt = 16'h0008;
        tick();
        reg_rd = 1'b0; mgmt_evt = '0;
        bus_rd(12'h200, rd);
        chk(rd == 32'h8, "R9 mgmt event survives clear", rd, 32'h8);

        // R12: management write keeps low half
        bus_wr(12'h200, 32'hFFFF_0005);
        bus_rd(12'h200, rd);
        chk(rd == 32'h5, "R12 mgmt status write", rd, 32'h5);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule